// File: doc/BRIEF.md
# Next-Page Codeword Exchange Controller

This block runs the next-page phase of link auto-negotiation between a local host and the remote partner. Once the base page exchange has finished, a start strobe tells it the toggle value of the last base page and whether the partner announced further pages. It then works in rounds. In each round it sends exactly one 48-bit page toward the line, waits for one page from the partner, and hands that page to the host. It then waits for the host to acknowledge that page before it sends the next one.

The host supplies only the payload and the message-protocol bit of each page. The block writes the next-page flag, the acknowledge flag, the second acknowledge flag and the toggle bit itself. When the host has no page pending, the block sends a null message page, so a partner with more to say can still finish. The exchange ends, with a one-cycle done strobe, after both sides have sent a page whose next-page flag is clear. Serialization and line coding belong to the neighbouring blocks, which use a simple word-plus-strobe port in each direction.

Top module: `npExchange`

## Requirements
- R1: A host page goes out with host word bits 47..16, bit 13 (message protocol) and bits 10..0 unchanged. Bits 15, 14, 12 and 11 of the host word have no effect on the sent page.
- R2: A host page is sent with bit 15 (next page) set to 1. `hostTxAck` is high for exactly one cycle, in the same cycle as the `lineTxValid` strobe of the page built from the sampled word.
- R3: When `hostTxReq` is 0 at send time, a null page is sent with no `hostTxAck`. A null page has bits 10..0 = 1, bit 13 = 1 and bit 15 = 0. Every other bit is 0 except the acknowledge bit 14 and the toggle bit 11.
- R4: Bit 11 (toggle) of the first page after a start equals the inverse of `baseTgl`, and it alternates on every later page. Bit 12 is always 0.
- R5: Bit 14 (acknowledge) is 0 on the first page after a start and 1 on every later page of that exchange.
- R6: A partner page strobed on `lineRxValid` appears on `hostRxWord` with `hostRxValid` high one cycle later. Both are held until the host acknowledges.
- R7: `hostRxValid` falls in the cycle after `hostRxAck` is seen. The next local page is strobed two cycles after the acknowledge.
- R8: When the local page and the partner page of a round both have bit 15 = 0, `doneOut` pulses for one cycle, one cycle after the host acknowledge, and no further page is sent.
- R9: A start with `hostTxReq` = 0 and `remoteNpIn` = 0 sends no page and pulses `doneOut` one cycle later.
- R10: `rst` or `restart` clears `hostRxValid`, stops the exchange and sends nothing further. A following start again derives the toggle from `baseTgl` and the acknowledge bit from a fresh first page.
- R11: No local page is sent while a partner page is waiting for the host acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Abandons the exchange and clears state |
| startIn | input | 1 | One-cycle strobe that begins the next-page phase |
| baseTgl | input | 1 | Toggle bit of the last base page |
| remoteNpIn | input | 1 | Partner base page announced next pages |
| hostTxReq | input | 1 | Host has a page ready on hostTxWord |
| hostTxWord | input | WORD_W | Host page payload with message-protocol bit |
| hostTxAck | output | 1 | One-cycle strobe: host word taken |
| hostRxWord | output | WORD_W | Last partner page |
| hostRxValid | output | 1 | hostRxWord holds an unacknowledged partner page |
| hostRxAck | input | 1 | Host has read the partner page |
| lineTxWord | output | WORD_W | Page toward the line |
| lineTxValid | output | 1 | One-cycle strobe: new page on lineTxWord |
| lineRxWord | input | WORD_W | Page received from the partner |
| lineRxValid | input | 1 | One-cycle strobe: new partner page |
| doneOut | output | 1 | One-cycle strobe: exchange complete |

## Verification
Every result has a fixed latency. The first page appears two cycles after the start strobe. A partner page reaches the host one cycle after its line strobe. The valid flag drops one cycle after the host acknowledge, and the next page follows two cycles after that acknowledge. The done strobe comes one cycle after the final acknowledge, or one cycle after a start with nothing to exchange. The bench drives inputs on the falling edge and samples on the falling edge that follows the exact number of rising edges. Each check therefore looks at the one cycle in which the result must appear. Pulse widths are confirmed by sampling again one cycle later.

// File: rtl/npExchPkg.sv
package npExchPkg;
  localparam int NP_POS   = 15;
  localparam int ACK_POS  = 14;
  localparam int MP_POS   = 13;
  localparam int ACK2_POS = 12;
  localparam int TGL_POS  = 11;
  localparam int MSG_W    = 11;
  localparam logic [MSG_W-1:0] NULL_CODE = 11'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAITRX,
    ST_WAITHOST,
    ST_FIN
  } npState_e;

  typedef struct packed {
    logic clearAll;
    logic initTgl;
    logic loadTx;
    logic txNull;
    logic captureRx;
    logic clearRx;
  } npStrobe_t;
endpackage

// File: rtl/npCtrl.sv
module npCtrl
  import npExchPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      startIn,
  input  logic      remoteNpIn,
  input  logic      hostTxReq,
  input  logic      hostRxAck,
  input  logic      lineRxValid,
  input  logic      localLast,
  input  logic      partnerLast,
  output npStrobe_t strobe,
  output logic      doneOut
);
  npState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst || restart) state <= ST_IDLE;
    else                state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.clearAll = rst || restart;
    if (!(rst || restart)) begin
      case (state)
        ST_IDLE: begin
          if (startIn) begin
            strobe.initTgl = 1'b1;
            stateNext = (hostTxReq || remoteNpIn) ? ST_SEND : ST_FIN;
          end
        end
        ST_SEND: begin
          strobe.loadTx = 1'b1;
          strobe.txNull = !hostTxReq;
          stateNext     = ST_WAITRX;
        end
        ST_WAITRX: begin
          if (lineRxValid) begin
            strobe.captureRx = 1'b1;
            stateNext        = ST_WAITHOST;
          end
        end
        ST_WAITHOST: begin
          if (hostRxAck) begin
            strobe.clearRx = 1'b1;
            stateNext = (localLast && partnerLast) ? ST_FIN : ST_SEND;
          end
        end
        ST_FIN:  stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign doneOut = (state == ST_FIN);
endmodule

// File: rtl/npDatapath.sv
module npDatapath
  import npExchPkg::*;
#(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  npStrobe_t         strobe,
  input  logic              baseTgl,
  input  logic [WORD_W-1:0] hostTxWord,
  input  logic [WORD_W-1:0] lineRxWord,
  output logic [WORD_W-1:0] lineTxWord,
  output logic              lineTxValid,
  output logic              hostTxAck,
  output logic [WORD_W-1:0] hostRxWord,
  output logic              hostRxValid,
  output logic              localLast,
  output logic              partnerLast
);
  logic              tgl;
  logic              firstPage;
  logic [WORD_W-1:0] txBuilt;

  always_comb begin
    if (strobe.txNull) begin
      txBuilt                = '0;
      txBuilt[MSG_W-1:0]     = NULL_CODE;
      txBuilt[MP_POS]        = 1'b1;
      txBuilt[NP_POS]        = 1'b0;
    end else begin
      txBuilt                = hostTxWord;
      txBuilt[NP_POS]        = 1'b1;
    end
    txBuilt[ACK_POS]  = !firstPage;
    txBuilt[ACK2_POS] = 1'b0;
    txBuilt[TGL_POS]  = tgl;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      tgl         <= 1'b0;
      firstPage   <= 1'b1;
      lineTxWord  <= '0;
      lineTxValid <= 1'b0;
      hostTxAck   <= 1'b0;
      hostRxWord  <= '0;
      hostRxValid <= 1'b0;
      localLast   <= 1'b0;
      partnerLast <= 1'b0;
    end else begin
      lineTxValid <= 1'b0;
      hostTxAck   <= 1'b0;
      if (strobe.initTgl) begin
        tgl         <= !baseTgl;
        firstPage   <= 1'b1;
        localLast   <= 1'b0;
        partnerLast <= 1'b0;
      end
      if (strobe.loadTx) begin
        lineTxWord  <= txBuilt;
        lineTxValid <= 1'b1;
        hostTxAck   <= !strobe.txNull;
        tgl         <= !tgl;
        firstPage   <= 1'b0;
        localLast   <= strobe.txNull;
      end
      if (strobe.captureRx) begin
        hostRxWord  <= lineRxWord;
        hostRxValid <= 1'b1;
        partnerLast <= !lineRxWord[NP_POS];
      end
      if (strobe.clearRx) hostRxValid <= 1'b0;
    end
  end
endmodule

// File: rtl/npExchange.sv
module npExchange
  import npExchPkg::*;
#(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              startIn,
  input  logic              baseTgl,
  input  logic              remoteNpIn,
  input  logic              hostTxReq,
  input  logic [WORD_W-1:0] hostTxWord,
  output logic              hostTxAck,
  output logic [WORD_W-1:0] hostRxWord,
  output logic              hostRxValid,
  input  logic              hostRxAck,
  output logic [WORD_W-1:0] lineTxWord,
  output logic              lineTxValid,
  input  logic [WORD_W-1:0] lineRxWord,
  input  logic              lineRxValid,
  output logic              doneOut
);
  npStrobe_t strobe;
  logic      localLast;
  logic      partnerLast;

  npCtrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .startIn     (startIn),
    .remoteNpIn  (remoteNpIn),
    .hostTxReq   (hostTxReq),
    .hostRxAck   (hostRxAck),
    .lineRxValid (lineRxValid),
    .localLast   (localLast),
    .partnerLast (partnerLast),
    .strobe      (strobe),
    .doneOut     (doneOut)
  );

  npDatapath #(.WORD_W(WORD_W)) i_dp (
    .clk         (clk),
    .strobe      (strobe),
    .baseTgl     (baseTgl),
    .hostTxWord  (hostTxWord),
    .lineRxWord  (lineRxWord),
    .lineTxWord  (lineTxWord),
    .lineTxValid (lineTxValid),
    .hostTxAck   (hostTxAck),
    .hostRxWord  (hostRxWord),
    .hostRxValid (hostRxValid),
    .localLast   (localLast),
    .partnerLast (partnerLast)
  );
endmodule

// File: rtl/npExchangeChk.sv
module npExchangeChk #(
  parameter int WORD_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              restart,
  input logic              hostTxAck,
  input logic [WORD_W-1:0] hostRxWord,
  input logic              hostRxValid,
  input logic              hostRxAck,
  input logic [WORD_W-1:0] lineTxWord,
  input logic              lineTxValid,
  input logic              doneOut
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    hostTxAck |=> !hostTxAck);
  p_ack_with_tx_r2: assert property (@(posedge clk) disable iff (rst)
    hostTxAck |-> lineTxValid);
  p_null_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (lineTxValid && !lineTxWord[15]) |-> (lineTxWord[10:0] == 11'd1 && lineTxWord[13]));
  p_ack2_zero_r4: assert property (@(posedge clk) disable iff (rst)
    lineTxValid |-> !lineTxWord[12]);
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hostRxValid && !hostRxAck && !restart) |=> (hostRxValid && $stable(hostRxWord)));
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (hostRxValid && hostRxAck) |=> !hostRxValid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!hostRxValid && !lineTxValid && !doneOut));
  p_no_tx_pending_r11: assert property (@(posedge clk) disable iff (rst)
    lineTxValid |-> !hostRxValid);
endmodule

bind npExchange npExchangeChk #(.WORD_W(WORD_W)) i_npExchangeChk (
  .clk         (clk),
  .rst         (rst),
  .restart     (restart),
  .hostTxAck   (hostTxAck),
  .hostRxWord  (hostRxWord),
  .hostRxValid (hostRxValid),
  .hostRxAck   (hostRxAck),
  .lineTxWord  (lineTxWord),
  .lineTxValid (lineTxValid),
  .doneOut     (doneOut)
);

// File: tb/test_npExchange.sv
module test_npExchange;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst, restart, startIn, baseTgl, remoteNpIn, hostTxReq;
  logic [W-1:0] hostTxWord, lineRxWord;
  logic         hostRxAck, lineRxValid;
  logic         hostTxAck, hostRxValid, lineTxValid, doneOut;
  logic [W-1:0] hostRxWord, lineTxWord;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  npExchange #(.WORD_W(W)) i_npExchange (
    .clk(clk), .rst(rst), .restart(restart), .startIn(startIn),
    .baseTgl(baseTgl), .remoteNpIn(remoteNpIn), .hostTxReq(hostTxReq),
    .hostTxWord(hostTxWord), .hostTxAck(hostTxAck), .hostRxWord(hostRxWord),
    .hostRxValid(hostRxValid), .hostRxAck(hostRxAck), .lineTxWord(lineTxWord),
    .lineTxValid(lineTxValid), .lineRxWord(lineRxWord),
    .lineRxValid(lineRxValid), .doneOut(doneOut)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] hostPage(input logic [W-1:0] w, input logic ack, input logic tgl);
    logic [W-1:0] r;
    r = w;
    r[15] = 1'b1; r[14] = ack; r[12] = 1'b0; r[11] = tgl;
    return r;
  endfunction

  function automatic logic [W-1:0] nullPage(input logic ack, input logic tgl);
    logic [W-1:0] r;
    r = '0;
    r[10:0] = 11'd1; r[13] = 1'b1; r[14] = ack; r[11] = tgl;
    return r;
  endfunction

  task automatic pulseStart();
    startIn = 1'b1; step(1); startIn = 1'b0;
  endtask

  task automatic partnerSends(input logic [W-1:0] w);
    lineRxWord = w; lineRxValid = 1'b1; step(1); lineRxValid = 1'b0;
    check("R6 rx valid", 64'(hostRxValid), 64'd1);
    check("R6 rx word", 64'(hostRxWord), 64'(w));
    step(2);
    check("R6 held valid", 64'(hostRxValid), 64'd1);
    check("R11 no tx while pending", 64'(lineTxValid), 64'd0);
  endtask

  task automatic hostAcks();
    hostRxAck = 1'b1; step(1); hostRxAck = 1'b0;
    check("R7 valid drops", 64'(hostRxValid), 64'd0);
  endtask

  task automatic testReset();
    check("R10 reset rx valid", 64'(hostRxValid), 64'd0);
    check("R10 reset tx valid", 64'(lineTxValid), 64'd0);
    check("R10 reset ack", 64'(hostTxAck), 64'd0);
    check("R10 reset done", 64'(doneOut), 64'd0);
  endtask

  task automatic testFullExchange();
    logic [W-1:0] wa, wb;
    wa = 48'hA5A5_1234_F8FF;
    wb = 48'h0123_4567_0055;
    baseTgl = 1'b0; remoteNpIn = 1'b1; hostTxReq = 1'b1; hostTxWord = wa;
    pulseStart();
    step(1);
    check("R1 first host page", 64'(lineTxWord), 64'(hostPage(wa, 1'b0, 1'b1)));
    check("R2 tx strobe", 64'(lineTxValid), 64'd1);
    check("R2 host ack", 64'(hostTxAck), 64'd1);
    hostTxWord = wb;
    step(1);
    check("R2 ack one cycle", 64'(hostTxAck), 64'd0);
    check("R2 tx strobe one cycle", 64'(lineTxValid), 64'd0);
    partnerSends(48'h1111_2222_8001);
    hostAcks();
    check("R8 no early done", 64'(doneOut), 64'd0);
    step(1);
    check("R7 next page after ack", 64'(lineTxValid), 64'd1);
    check("R5 R4 second page ack toggle", 64'(lineTxWord), 64'(hostPage(wb, 1'b1, 1'b0)));
    hostTxReq = 1'b0;
    partnerSends(48'h3333_4444_0002);
    hostAcks();
    step(1);
    check("R3 null page strobe", 64'(lineTxValid), 64'd1);
    check("R3 null page word", 64'(lineTxWord), 64'(nullPage(1'b1, 1'b1)));
    check("R3 no host ack on null", 64'(hostTxAck), 64'd0);
    partnerSends(48'h0000_0000_6001);
    hostAcks();
    check("R8 done pulse", 64'(doneOut), 64'd1);
    step(1);
    check("R8 done one cycle", 64'(doneOut), 64'd0);
    step(2);
    check("R8 no page after done", 64'(lineTxValid), 64'd0);
  endtask

  task automatic testNullOnly();
    baseTgl = 1'b1; remoteNpIn = 1'b1; hostTxReq = 1'b0;
    pulseStart();
    step(1);
    check("R3 null first page", 64'(lineTxWord), 64'(nullPage(1'b0, 1'b0)));
    check("R3 null no ack", 64'(hostTxAck), 64'd0);
    partnerSends(48'h0000_0000_0001);
    hostAcks();
    check("R8 done after null round", 64'(doneOut), 64'd1);
  endtask

  task automatic testNothing();
    baseTgl = 1'b0; remoteNpIn = 1'b0; hostTxReq = 1'b0;
    pulseStart();
    check("R9 immediate done", 64'(doneOut), 64'd1);
    check("R9 no page", 64'(lineTxValid), 64'd0);
    step(1);
    check("R9 done one cycle", 64'(doneOut), 64'd0);
    check("R9 still no page", 64'(lineTxValid), 64'd0);
  endtask

  task automatic testRestart();
    logic [W-1:0] wc;
    wc = 48'hFFFF_0000_2ABC;
    baseTgl = 1'b1; remoteNpIn = 1'b1; hostTxReq = 1'b1; hostTxWord = wc;
    pulseStart();
    step(1);
    check("R4 toggle from base", 64'(lineTxWord), 64'(hostPage(wc, 1'b0, 1'b0)));
    partnerSends(48'h5555_6666_8003);
    restart = 1'b1; step(1); restart = 1'b0;
    check("R10 restart clears valid", 64'(hostRxValid), 64'd0);
    step(3);
    check("R10 restart stops tx", 64'(lineTxValid), 64'd0);
    baseTgl = 1'b0;
    pulseStart();
    step(1);
    check("R10 fresh first page", 64'(lineTxWord), 64'(hostPage(wc, 1'b0, 1'b1)));
    rst = 1'b1; step(1); rst = 1'b0;
    check("R10 reset clears tx", 64'(lineTxValid), 64'd0);
    check("R10 reset clears rx", 64'(hostRxValid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; restart = 1'b0; startIn = 1'b0; baseTgl = 1'b0;
    remoteNpIn = 1'b0; hostTxReq = 1'b0; hostTxWord = '0;
    lineRxWord = '0; lineRxValid = 1'b0; hostRxAck = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    testReset();
    testFullExchange();
    step(2);
    testNullOnly();
    step(2);
    testNothing();
    step(2);
    testRestart();
    step(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule